// File: doc/BRIEF.md
# VGA General Register Port Decoder

This block is the general register group of a VGA-style display controller, sitting on an 8-bit CPU I/O port bus. It owns the Miscellaneous Output register, breaks its fields out into the pixel clock select, the sync polarities, the odd/even page bit and the color/mono addressing bit, and answers reads of the two fixed-value status/feature ports and of the retrace status port. The retrace inputs are synchronized before they reach the status value.

The color/mono bit moves the CRTC index port, the CRTC data port and the retrace status port between the 0x3Bx and 0x3Dx ranges at run time. The block does not hold CRTC, attribute or sequencer state. It only produces one-cycle strobes for the CRTC and a one-cycle clear for the attribute controller's index/data flip-flop, and that clear fires whenever the active status port is read.

All outputs are registered. A bus request presented during one clock is answered, and its strobes are issued, in the cycle after that clock edge.

Top module: `vga_genreg_decoder`

## Requirements
- R1: A write to port 0x03C2 loads the 8-bit Miscellaneous Output value. A read of port 0x03CC returns it. Writes to any other port, including 0x03CC, leave it unchanged.
- R2: During and after reset, Miscellaneous Output is 0x00, every decoded field and strobe is 0, io_rdata is 0xFF and io_rvalid is 0.
- R3: The decoded outputs follow the register: color_sel = bit 0, clk_sel = bits 3:2 (0 for 25 MHz, 1 for 28 MHz), page_hi = bit 5, hsync_neg = bit 6 and vsync_neg = bit 7. The pair {vsync_neg,hsync_neg} is the line-count code, where 1 means 400 lines, 2 means 350 lines and 3 means 480 lines.
- R4: A read of port 0x03C2 returns 0x70, and a read of port 0x03CA returns 0x00.
- R5: A status read returns bit 0 = hretrace OR vretrace and bit 3 = vretrace, with all other bits 0. A retrace level held for three clocks before the read is reflected.
- R6: The status port is 0x03DA when color_sel is 1 and 0x03BA when it is 0. The unselected one reads as unmapped.
- R7: attr_ff_clr pulses for exactly one cycle after every read of the active status port, and at no other time.
- R8: crtc_idx_wr, crtc_dat_wr and crtc_dat_rd pulse for one cycle after, respectively, a write to index port x4, a write to data port x5 and a read of data port x5. This applies only in the range selected by color_sel (0x03Dx when set, 0x03Bx when clear).
- R9: Reads of unmapped ports, including CRTC ports, return 0xFF with io_rvalid 0. All 16 address bits are decoded, so for example 0x13C2 is unmapped.
- R10: io_rvalid and io_rdata are valid for exactly one cycle after the read cycle. When no read is answered, io_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write request, one cycle |
| io_rd | input | 1 | Read request, one cycle |
| io_rdata | output | 8 | Read data, 0xFF when not answering |
| io_rvalid | output | 1 | Read answered by this block |
| hretrace_in | input | 1 | Horizontal retrace, asynchronous |
| vretrace_in | input | 1 | Vertical retrace, asynchronous |
| color_sel | output | 1 | 1: 0x3Dx addressing, 0: 0x3Bx |
| clk_sel | output | 2 | Pixel clock select |
| page_hi | output | 1 | High 64K bank in odd/even modes |
| hsync_neg | output | 1 | Negative horizontal sync |
| vsync_neg | output | 1 | Negative vertical sync |
| crtc_idx_wr | output | 1 | CRTC index write strobe |
| crtc_dat_wr | output | 1 | CRTC data write strobe |
| crtc_dat_rd | output | 1 | CRTC data read strobe |
| attr_ff_clr | output | 1 | Attribute flip-flop clear pulse |

## Verification
The bench repeatedly flips the color/mono bit with random Miscellaneous Output writes and then hits both the 0x3Bx and 0x3Dx CRTC and status ports. A decoder that latched the range once, or swapped the two ranges, would strobe the CRTC or clear the attribute flip-flop from the wrong port. It reads 0x03CC after writes to 0x03CC and to aliases such as 0x13C2, so a design that decoded only ten address bits, or that treated the readback port as writable, would corrupt the register. Retrace combinations are changed and held before status reads, which catches swapped status bits, a missing OR into bit 0, and stray bits. Every idle cycle is checked for 0xFF and no valid flag, which catches a response that lingers past one cycle.

// File: rtl/vga_genreg_pkg.sv
package vga_genreg_pkg;

   // Port numbers (low 16 bits of the I/O address space)
   localparam logic [15:0] PORT_MISC_WR   = 16'h03C2;
   localparam logic [15:0] PORT_MISC_RD   = 16'h03CC;
   localparam logic [15:0] PORT_FEAT_RD   = 16'h03CA;
   localparam logic [15:0] PORT_MONO_BASE = 16'h03B0;
   localparam logic [15:0] PORT_COLR_BASE = 16'h03D0;
   localparam logic [3:0]  OFS_CRTC_IDX   = 4'h4;
   localparam logic [3:0]  OFS_CRTC_DAT   = 4'h5;
   localparam logic [3:0]  OFS_STATUS     = 4'hA;

   typedef struct packed {
      logic       vsync_neg;   // bit 7
      logic       hsync_neg;   // bit 6
      logic       page_hi;     // bit 5
      logic       rsvd4;       // bit 4
      logic [1:0] clk_sel;     // bits 3:2
      logic       rsvd1;       // bit 1
      logic       color_sel;   // bit 0
   } misc_t;

   typedef struct packed {
      logic misc_wr;
      logic misc_rd;
      logic is0_rd;
      logic feat_rd;
      logic stat_rd;
      logic idx_wr;
      logic dat_wr;
      logic dat_rd;
   } hits_t;

   function automatic logic [15:0] range_base(input logic color);
      return color ? PORT_COLR_BASE : PORT_MONO_BASE;
   endfunction

endpackage

// File: rtl/vga_genreg_misc.sv
module vga_genreg_misc
   import vga_genreg_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  RESET_VAL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output misc_t             q
);

   generate
      if (DATA_W != $bits(misc_t)) begin : g_width_bad
         $error("vga_genreg_misc: DATA_W must match the register layout");
      end
   endgenerate

   misc_t q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= misc_t'(RESET_VAL);
      end else if (load) begin
         q_r <= misc_t'(din);
      end
   end

   assign q = q_r;

endmodule

// File: rtl/vga_genreg_sync.sv
module vga_genreg_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_stages_bad
         $error("vga_genreg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_width_bad
         $error("vga_genreg_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain[s] <= '0;
            end else begin
               if (s == 0) chain[s] <= d;
               else        chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/vga_genreg_addr_dec.sv
module vga_genreg_addr_dec
   import vga_genreg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              color,
   output hits_t             hits
);

   localparam int LOW_W = 10;

   generate
      if (ADDR_W < LOW_W) begin : g_addr_bad
         $error("vga_genreg_addr_dec: ADDR_W must be at least 10");
      end
   endgenerate

   logic             upper_ok;
   logic [LOW_W-1:0] lo;
   logic [15:0]      base;
   logic             in_range;
   logic [3:0]       ofs;

   generate
      if (FULL_DECODE && ADDR_W > LOW_W) begin : g_full
         assign upper_ok = (addr[ADDR_W-1:LOW_W] == '0);
      end else begin : g_partial
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign lo       = addr[LOW_W-1:0];
   assign base     = range_base(color);
   assign in_range = upper_ok && (lo[LOW_W-1:4] == base[LOW_W-1:4]);
   assign ofs      = lo[3:0];

   always_comb begin
      hits         = '0;
      hits.misc_wr = wr && upper_ok && (lo == PORT_MISC_WR[LOW_W-1:0]);
      hits.misc_rd = rd && upper_ok && (lo == PORT_MISC_RD[LOW_W-1:0]);
      hits.is0_rd  = rd && upper_ok && (lo == PORT_MISC_WR[LOW_W-1:0]);
      hits.feat_rd = rd && upper_ok && (lo == PORT_FEAT_RD[LOW_W-1:0]);
      hits.stat_rd = rd && in_range && (ofs == OFS_STATUS);
      hits.idx_wr  = wr && in_range && (ofs == OFS_CRTC_IDX);
      hits.dat_wr  = wr && in_range && (ofs == OFS_CRTC_DAT);
      hits.dat_rd  = rd && in_range && (ofs == OFS_CRTC_DAT);
   end

endmodule

// File: rtl/vga_genreg_decoder.sv
module vga_genreg_decoder
   import vga_genreg_pkg::*;
#(
   parameter int         ADDR_W      = 16,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         FULL_DECODE = 1'b1,
   parameter logic [7:0] IS0_VALUE   = 8'h70,
   parameter logic [7:0] FEAT_VALUE  = 8'h00,
   parameter logic [7:0] IDLE_VALUE  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rvalid,
   input  logic              hretrace_in,
   input  logic              vretrace_in,
   output logic              color_sel,
   output logic [1:0]        clk_sel,
   output logic              page_hi,
   output logic              hsync_neg,
   output logic              vsync_neg,
   output logic              crtc_idx_wr,
   output logic              crtc_dat_wr,
   output logic              crtc_dat_rd,
   output logic              attr_ff_clr
);

   localparam int RETRACE_W = 2;

   generate
      if (DATA_W != 8) begin : g_data_bad
         $error("vga_genreg_decoder: DATA_W must be 8");
      end
   endgenerate

   misc_t                 misc_q;
   hits_t                 hits;
   logic [RETRACE_W-1:0]  retr_s;
   logic                  h_s, v_s;
   logic [DATA_W-1:0]     rd_val;
   logic                  rd_hit;

   vga_genreg_addr_dec #(
      .ADDR_W      (ADDR_W),
      .FULL_DECODE (FULL_DECODE)
   ) u_dec (
      .addr  (io_addr),
      .wr    (io_wr),
      .rd    (io_rd),
      .color (misc_q.color_sel),
      .hits  (hits)
   );

   vga_genreg_misc #(
      .DATA_W    (DATA_W),
      .RESET_VAL (8'h00)
   ) u_misc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hits.misc_wr),
      .din   (io_wdata),
      .q     (misc_q)
   );

   vga_genreg_sync #(
      .WIDTH  (RETRACE_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({vretrace_in, hretrace_in}),
      .q     (retr_s)
   );

   assign h_s = retr_s[0];
   assign v_s = retr_s[1];

   always_comb begin
      rd_val = IDLE_VALUE;
      rd_hit = 1'b0;
      if (hits.misc_rd) begin
         rd_val = misc_q;
         rd_hit = 1'b1;
      end else if (hits.is0_rd) begin
         rd_val = IS0_VALUE;
         rd_hit = 1'b1;
      end else if (hits.feat_rd) begin
         rd_val = FEAT_VALUE;
         rd_hit = 1'b1;
      end else if (hits.stat_rd) begin
         rd_val = {4'b0000, v_s, 2'b00, h_s | v_s};
         rd_hit = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rdata    <= IDLE_VALUE;
         io_rvalid   <= 1'b0;
         crtc_idx_wr <= 1'b0;
         crtc_dat_wr <= 1'b0;
         crtc_dat_rd <= 1'b0;
         attr_ff_clr <= 1'b0;
      end else begin
         io_rdata    <= rd_val;
         io_rvalid   <= rd_hit;
         crtc_idx_wr <= hits.idx_wr;
         crtc_dat_wr <= hits.dat_wr;
         crtc_dat_rd <= hits.dat_rd;
         attr_ff_clr <= hits.stat_rd;
      end
   end

   assign color_sel = misc_q.color_sel;
   assign clk_sel   = misc_q.clk_sel;
   assign page_hi   = misc_q.page_hi;
   assign hsync_neg = misc_q.hsync_neg;
   assign vsync_neg = misc_q.vsync_neg;

endmodule

// File: rtl/vga_genreg_decoder_chk.sv
module vga_genreg_decoder_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              io_rvalid,
   input logic              color_sel,
   input logic [1:0]        clk_sel,
   input logic              crtc_idx_wr,
   input logic              crtc_dat_rd,
   input logic              attr_ff_clr
);

   // R1
   misc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr) && $past(io_addr) == ADDR_W'(16'h03C2))
      |-> (color_sel == $past(io_wdata[0]) && clk_sel == $past(io_wdata[3:2])));

   // R7
   attr_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attr_ff_clr |-> ($past(io_rd) && $past(io_addr[3:0]) == 4'hA &&
                       $past(io_addr[7:4]) == ($past(color_sel) ? 4'hD : 4'hB)));

   // R8
   crtc_idx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crtc_idx_wr |-> ($past(io_wr) && $past(io_addr[3:0]) == 4'h4 &&
                       $past(io_addr[7:4]) == ($past(color_sel) ? 4'hD : 4'hB)));

   // R8
   crtc_rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crtc_dat_rd |-> ($past(io_rd) && $past(io_addr[3:0]) == 4'h5));

   // R10
   rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rvalid |-> $past(io_rd));

   // R9
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rvalid |-> io_rdata == 8'hFF);

   // R5
   status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attr_ff_clr |-> (io_rvalid && io_rdata[7:4] == 4'h0 && io_rdata[2:1] == 2'b00 &&
                       (!io_rdata[3] || io_rdata[0])));

endmodule

bind vga_genreg_decoder vga_genreg_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wdata    (io_wdata),
   .io_wr       (io_wr),
   .io_rd       (io_rd),
   .io_rdata    (io_rdata),
   .io_rvalid   (io_rvalid),
   .color_sel   (color_sel),
   .clk_sel     (clk_sel),
   .crtc_idx_wr (crtc_idx_wr),
   .crtc_dat_rd (crtc_dat_rd),
   .attr_ff_clr (attr_ff_clr)
);

// File: tb/vga_genreg_decoder_test.sv
`timescale 1ns/1ps
module vga_genreg_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        io_rvalid;
   logic        hretrace_in = 1'b0, vretrace_in = 1'b0;
   logic        color_sel, page_hi, hsync_neg, vsync_neg;
   logic [1:0]  clk_sel;
   logic        crtc_idx_wr, crtc_dat_wr, crtc_dat_rd, attr_ff_clr;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic [7:0] m_misc = 8'h00;

   always #2 clk = ~clk;

   vga_genreg_decoder uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .hretrace_in(hretrace_in), .vretrace_in(vretrace_in),
      .color_sel(color_sel), .clk_sel(clk_sel), .page_hi(page_hi),
      .hsync_neg(hsync_neg), .vsync_neg(vsync_neg),
      .crtc_idx_wr(crtc_idx_wr), .crtc_dat_wr(crtc_dat_wr),
      .crtc_dat_rd(crtc_dat_rd), .attr_ff_clr(attr_ff_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sel_base(input logic [7:0] m);
      return m[0] ? 8'hD0 : 8'hB0;
   endfunction

   // expected read answer {valid, data}
   function automatic logic [8:0] exp_read(input logic [15:0] a, input logic [7:0] m,
                                           input logic h, input logic v);
      if (a == 16'h03CC) return {1'b1, m};
      if (a == 16'h03C2) return {1'b1, 8'h70};
      if (a == 16'h03CA) return {1'b1, 8'h00};
      if (a == {8'h03, sel_base(m) | 8'h0A}) return {1'b1, 4'h0, v, 2'b00, h | v};
      return {1'b0, 8'hFF};
   endfunction

   task automatic check_fields(input string req);
      check({req, " color_sel"}, 32'(color_sel), 32'(m_misc[0]));
      check({req, " clk_sel"},   32'(clk_sel),   32'(m_misc[3:2]));
      check({req, " page_hi"},   32'(page_hi),   32'(m_misc[5]));
      check({req, " sync/lines"}, 32'({vsync_neg, hsync_neg}), 32'(m_misc[7:6]));
   endtask

   // one bus op; drive at negedge, sample at following negedge
   task automatic bus_op(input bit is_wr, input logic [15:0] a, input logic [7:0] d);
      logic [8:0] er;
      logic       col;
      col = m_misc[0];
      er  = is_wr ? {1'b0, 8'hFF} : exp_read(a, m_misc, hretrace_in, vretrace_in);
      io_addr = a; io_wdata = d; io_wr = is_wr; io_rd = !is_wr;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      if (is_wr && a == 16'h03C2) m_misc = d;
      check("R10/R4/R5/R9 rvalid", 32'(io_rvalid), 32'(er[8]));
      check("R1/R4/R5/R9 rdata",   32'(io_rdata),  32'(er[7:0]));
      check("R7 attr_ff_clr", 32'(attr_ff_clr),
            32'(!is_wr && a == {8'h03, (col ? 8'hDA : 8'hBA)}));
      check("R8 crtc_idx_wr", 32'(crtc_idx_wr),
            32'(is_wr && a == {8'h03, (col ? 8'hD4 : 8'hB4)}));
      check("R8 crtc_dat_wr", 32'(crtc_dat_wr),
            32'(is_wr && a == {8'h03, (col ? 8'hD5 : 8'hB5)}));
      check("R8 crtc_dat_rd", 32'(crtc_dat_rd),
            32'(!is_wr && a == {8'h03, (col ? 8'hD5 : 8'hB5)}));
      check_fields("R3");
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("R10 idle rvalid", 32'(io_rvalid), 32'd0);
      check("R10 idle rdata",  32'(io_rdata),  32'hFF);
      check("R7 idle clear",   32'(attr_ff_clr), 32'd0);
   endtask

   task automatic set_retrace(input logic h, input logic v);
      hretrace_in = h; vretrace_in = v;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [15:0] pick_addr(input int unsigned r);
      case (r % 12)
         0: return 16'h03C2;  1: return 16'h03CC;  2: return 16'h03CA;
         3: return 16'h03BA;  4: return 16'h03DA;  5: return 16'h03B4;
         6: return 16'h03B5;  7: return 16'h03D4;  8: return 16'h03D5;
         9: return 16'h13C2; 10: return 16'h83DA;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      // R2 reset state
      check("R2 rdata", 32'(io_rdata), 32'hFF);
      check("R2 rvalid", 32'(io_rvalid), 32'd0);
      check("R2 strobes", 32'({crtc_idx_wr, crtc_dat_wr, crtc_dat_rd, attr_ff_clr}), 32'd0);
      check_fields("R2");
      rst_n = 1'b1;
      @(negedge clk);
      bus_op(1'b0, 16'h03CC, 8'h00);            // R2 readback zero
      // R4 fixed ports
      bus_op(1'b0, 16'h03C2, 8'h00);
      bus_op(1'b0, 16'h03CA, 8'h00);
      // R6 mono: status at 3BA, 3DA unmapped
      set_retrace(1'b1, 1'b0);
      bus_op(1'b0, 16'h03BA, 8'h00);
      bus_op(1'b0, 16'h03DA, 8'h00);
      // R1 write, readback, ignored writes
      bus_op(1'b1, 16'h03C2, 8'hE1);
      bus_op(1'b0, 16'h03CC, 8'h00);
      bus_op(1'b1, 16'h03CC, 8'h5A);
      bus_op(1'b1, 16'h13C2, 8'h02);
      bus_op(1'b0, 16'h03CC, 8'h00);
      idle_check();
      // R5 retrace combinations in color mode
      set_retrace(1'b0, 1'b1);
      bus_op(1'b0, 16'h03DA, 8'h00);
      set_retrace(1'b1, 1'b1);
      bus_op(1'b0, 16'h03DA, 8'h00);
      set_retrace(1'b0, 1'b0);
      bus_op(1'b0, 16'h03DA, 8'h00);
      bus_op(1'b0, 16'h03BA, 8'h00);
      // R8 color-range strobes, mono range silent
      bus_op(1'b1, 16'h03D4, 8'h11);
      bus_op(1'b1, 16'h03D5, 8'h22);
      bus_op(1'b0, 16'h03D5, 8'h00);
      bus_op(1'b1, 16'h03B4, 8'h11);
      bus_op(1'b0, 16'h03B5, 8'h00);
      // R3 line-count codes
      for (int k = 0; k < 4; k++) begin
         bus_op(1'b1, 16'h03C2, {2'(k), 6'h0C});
         bus_op(1'b0, 16'h03CC, 8'h00);
      end
      // random mix
      for (int n = 0; n < 1500; n++) begin
         if (n % 50 == 0) set_retrace(1'($urandom), 1'($urandom));
         bus_op(1'($urandom), pick_addr($urandom), 8'($urandom));
         if (n % 7 == 0) idle_check();
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule